// File: doc/BRIEF.md
# Scanout position calculator

This block turns a snapshot of a display timing counter into a position that is measured from the end of vertical blanking. The counter is either a frame-wide pixel counter or a plain line counter. The caller presents the counter value and the current mode timing (horizontal total, horizontal sync start, and the vertical blank start, blank end and total in lines), raises `start` for one cycle, and collects a signed vertical position, a horizontal position and an in-blank flag when `done` pulses.

Inside vertical blank the reported position is negative and rises toward zero as blank end approaches. In the visible region it is positive. Pixel counts are first rebased so that blank entry coincides with the horizontal sync start of the first blank line. They are clamped so that the longer field of an interlaced frame cannot wrap the result. In pixel-counter mode a restoring divider, one quotient bit per cycle, splits the signed pixel offset into a line and a column.

Top module: `scanpos_calc`

## Requirements
- R1: `start` is sampled only while `busy` is low. Once a request is taken, `busy` stays high until the result is produced. `done` is high for exactly one cycle, and the result outputs hold their values until the next `done`.
- R2: A `start` pulse that arrives while `busy` is high is ignored. It produces no extra `done` and does not alter the result of the request in flight.
- R3: When `interlace` is 1, the blank start in lines is halved with rounding up, and the blank end and the total in lines are halved with rounding down. This happens before any other step.
- R4: When `pix_mode` is 1, the blank start, blank end and total (all in lines) are multiplied by `htotal` to give pixel counts.
- R5: When `pix_mode` is 1, a counter value at or above the scaled total is replaced by the scaled total minus one.
- R6: When `pix_mode` is 1, the position becomes (position + `htotal` − `hsync_start`) modulo the scaled total.
- R7: If the position is at or above the blank start, the signed offset is position − blank end. Otherwise it is position + total − blank end.
- R8: When `pix_mode` is 0, `vpos` equals the signed offset in lines and `hpos` is 0.
- R9: When `pix_mode` is 1, `vpos` is the signed offset divided by `htotal`, truncated toward zero. `hpos` is the offset minus `vpos`×`htotal`, so it has the sign of the offset and its magnitude is below `htotal`.
- R10: `in_vbl` is 1 exactly when the signed offset is negative.
- R11: After reset, `busy`, `done`, `in_vbl`, `vpos` and `hpos` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken when idle |
| pix_mode | input | 1 | 1: pixel-counter input, 0: line-counter input |
| interlace | input | 1 | Interlaced mode timing |
| raw_pos | input | LW+HW | Counter snapshot (pixels or lines) |
| htotal | input | HW | Pixels per line |
| hsync_start | input | HW | Pixel index of horizontal sync start |
| vbl_start | input | LW | First blank line |
| vbl_end | input | LW | Line where blank ends |
| vtotal | input | LW | Lines per frame |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle result strobe |
| in_vbl | output | 1 | Signed offset is negative |
| vpos | output | LW+1 | Signed vertical position |
| hpos | output | HW+1 | Signed horizontal position |

## Verification
The hardest cases to reach are the pixel positions that sit just around the rebased blank boundary. A counter value one pixel before the hsync-shifted blank entry must stay positive, and the next value must flip to a large negative offset. A small negative offset inside the last blank line must give a line of zero but a negative column and a set in-blank flag. The stimulus table sets these positions directly by choosing counter values a fixed number of pixels before the scaled blank start, with a small mode and with a large one. It also places a counter value beyond the scaled total to force the clamp and the modulo wrap. A directed test pulses `start` again while the divider is busy, then checks that the first answer stands and that no second strobe follows.

// File: rtl/scanpos_pkg.sv
package scanpos_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PREP = 2'd1,
      ST_DIV  = 2'd2
   } scanpos_st_e;
endpackage

// File: rtl/scanpos_norm.sv
module scanpos_norm #(
   parameter int LW    = 12,
   parameter int HW    = 14,
   parameter bit IL_EN = 1'b1,
   localparam int PW   = LW + HW,
   localparam int XW   = PW + 2
) (
   input  logic                 pix,
   input  logic                 il,
   input  logic [PW-1:0]        raw,
   input  logic [HW-1:0]        ht,
   input  logic [HW-1:0]        hs,
   input  logic [LW-1:0]        vs,
   input  logic [LW-1:0]        ve,
   input  logic [LW-1:0]        vt,
   output logic signed [XW-1:0] off
);
   logic [LW-1:0] vs_h, ve_h, vt_h;
   logic [XW-1:0] vs_x, ve_x, vt_x;
   logic [XW-1:0] pos, off_u;

   generate
      if (IL_EN) begin : g_il
         // R3: field timing, blank start rounded up, the rest rounded down
         assign vs_h = il ? LW'(({1'b0, vs} + (LW+1)'(1)) >> 1) : vs;
         assign ve_h = il ? (ve >> 1) : ve;
         assign vt_h = il ? (vt >> 1) : vt;
      end else begin : g_prog
         assign vs_h = vs;
         assign ve_h = ve;
         assign vt_h = vt;
      end
   endgenerate

   always_comb begin
      // R4: scale line values to pixel counts
      if (pix) begin
         vs_x = XW'(vs_h) * XW'(ht);
         ve_x = XW'(ve_h) * XW'(ht);
         vt_x = XW'(vt_h) * XW'(ht);
      end else begin
         vs_x = XW'(vs_h);
         ve_x = XW'(ve_h);
         vt_x = XW'(vt_h);
      end
      pos = XW'(raw);
      if (pix) begin
         // R5: clamp into the shorter field
         if (pos >= vt_x)
            pos = vt_x - XW'(1);
         // R6: rebase to hsync start, single-step wrap
         pos = pos + XW'(ht) - XW'(hs);
         if (pos >= vt_x)
            pos = pos - vt_x;
      end
      // R7: signed distance from blank end
      if (pos >= vs_x)
         off_u = pos - ve_x;
      else
         off_u = pos + vt_x - ve_x;
   end

   assign off = $signed(off_u);
endmodule

// File: rtl/scanpos_divu.sv
module scanpos_divu #(
   parameter int NW  = 28,
   parameter int DW  = 14,
   localparam int CW = $clog2(NW + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [NW-1:0] dividend,
   input  logic [DW-1:0] divisor,
   output logic          fin,
   output logic [NW-1:0] quo,
   output logic [DW-1:0] rem
);
   logic [NW-1:0] acc;
   logic [DW-1:0] rem_q, den_q;
   logic [CW-1:0] cnt;
   logic          run;
   logic [DW:0]   shifted, nrem;
   logic          ge;

   generate
      if (NW < 2 || DW < 2) begin : g_bad_width
         $error("scanpos_divu: widths too small");
      end
   endgenerate

   always_comb begin
      shifted = {rem_q, acc[NW-1]};
      ge      = shifted >= {1'b0, den_q};
      nrem    = ge ? (shifted - {1'b0, den_q}) : shifted;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc   <= '0;
         rem_q <= '0;
         den_q <= '0;
         cnt   <= '0;
         run   <= 1'b0;
         fin   <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (go) begin
            acc   <= dividend;
            rem_q <= '0;
            den_q <= divisor;
            cnt   <= CW'(NW - 1);
            run   <= 1'b1;
         end else if (run) begin
            acc   <= {acc[NW-2:0], ge};
            rem_q <= nrem[DW-1:0];
            if (cnt == '0) begin
               run <= 1'b0;
               fin <= 1'b1;
            end else begin
               cnt <= cnt - CW'(1);
            end
         end
      end
   end

   assign quo = acc;
   assign rem = rem_q;

   // R9
   rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && den_q != '0) |-> (rem_q < den_q));
endmodule

// File: rtl/scanpos_calc.sv
module scanpos_calc
   import scanpos_pkg::*;
#(
   parameter int LW    = 12,
   parameter int HW    = 14,
   parameter bit IL_EN = 1'b1,
   localparam int PW   = LW + HW,
   localparam int XW   = PW + 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 pix_mode,
   input  logic                 interlace,
   input  logic [PW-1:0]        raw_pos,
   input  logic [HW-1:0]        htotal,
   input  logic [HW-1:0]        hsync_start,
   input  logic [LW-1:0]        vbl_start,
   input  logic [LW-1:0]        vbl_end,
   input  logic [LW-1:0]        vtotal,
   output logic                 busy,
   output logic                 done,
   output logic                 in_vbl,
   output logic signed [LW:0]   vpos,
   output logic signed [HW:0]   hpos
);
   scanpos_st_e          st;
   logic                 pix_q, il_q;
   logic [PW-1:0]        raw_q;
   logic [HW-1:0]        ht_q, hs_q;
   logic [LW-1:0]        vs_q, ve_q, vt_q;
   logic                 neg_q;
   logic signed [XW-1:0] off;
   logic [XW-1:0]        mag;
   logic                 div_go, div_fin;
   logic [XW-1:0]        quo;
   logic [HW-1:0]        rem;
   logic signed [LW:0]   qv;
   logic signed [HW:0]   rv;

   generate
      if (LW < 2 || HW < 2) begin : g_bad_width
         $error("scanpos_calc: LW and HW must be at least 2");
      end
   endgenerate

   scanpos_norm #(.LW(LW), .HW(HW), .IL_EN(IL_EN)) u_norm (
      .pix (pix_q),
      .il  (il_q),
      .raw (raw_q),
      .ht  (ht_q),
      .hs  (hs_q),
      .vs  (vs_q),
      .ve  (ve_q),
      .vt  (vt_q),
      .off (off)
   );

   assign mag    = off[XW-1] ? XW'(-off) : XW'(off);
   assign div_go = (st == ST_PREP) && pix_q;

   scanpos_divu #(.NW(XW), .DW(HW)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (div_go),
      .dividend (mag),
      .divisor  (ht_q),
      .fin      (div_fin),
      .quo      (quo),
      .rem      (rem)
   );

   assign qv   = $signed({1'b0, quo[LW-1:0]});
   assign rv   = $signed({1'b0, rem});
   assign busy = (st != ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         pix_q  <= 1'b0;
         il_q   <= 1'b0;
         raw_q  <= '0;
         ht_q   <= '0;
         hs_q   <= '0;
         vs_q   <= '0;
         ve_q   <= '0;
         vt_q   <= '0;
         neg_q  <= 1'b0;
         done   <= 1'b0;
         in_vbl <= 1'b0;
         vpos   <= '0;
         hpos   <= '0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  pix_q <= pix_mode;
                  il_q  <= interlace;
                  raw_q <= raw_pos;
                  ht_q  <= htotal;
                  hs_q  <= hsync_start;
                  vs_q  <= vbl_start;
                  ve_q  <= vbl_end;
                  vt_q  <= vtotal;
                  st    <= ST_PREP;
               end
            end
            ST_PREP: begin
               neg_q <= off[XW-1];
               if (pix_q) begin
                  st <= ST_DIV;
               end else begin
                  // R8: line mode, no division
                  vpos   <= $signed(off[LW:0]);
                  hpos   <= '0;
                  in_vbl <= off[XW-1];
                  done   <= 1'b1;
                  st     <= ST_IDLE;
               end
            end
            ST_DIV: begin
               if (div_fin) begin
                  // R9: truncation toward zero, remainder follows sign
                  vpos   <= neg_q ? -qv : qv;
                  hpos   <= neg_q ? -rv : rv;
                  in_vbl <= neg_q;
                  done   <= 1'b1;
                  st     <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R1
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));

   // R10
   vbl_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (in_vbl == (vpos < 0 || hpos < 0)));

   // R8
   line_hpos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !pix_q) |-> (hpos == '0));

   // R9
   hpos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && pix_q) |-> ((hpos < 0 ? -hpos : hpos) < $signed({1'b0, ht_q})));

   // R9
   quo_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_fin |-> (quo[XW-1:LW] == '0));
endmodule

// File: tb/scanpos_calc_tb.sv
module scanpos_calc_tb;
   localparam int LW = 12;
   localparam int HW = 14;
   localparam int PW = LW + HW;

   typedef struct packed {
      logic                 pix;
      logic                 il;
      logic [PW-1:0]        raw;
      logic [HW-1:0]        ht;
      logic [HW-1:0]        hs;
      logic [LW-1:0]        vs;
      logic [LW-1:0]        ve;
      logic [LW-1:0]        vt;
      logic signed [LW:0]   ev;
      logic signed [HW:0]   eh;
      logic                 eb;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VEC [NV] = '{
      // progressive pixel mode: ht 10, hs 8, blank 6..9, total 10 (R4 R6 R7 R9 R10)
      '{1'b1, 1'b0, 26'd0,  14'd10, 14'd8, 12'd6, 12'd9, 12'd10,  13'sd1,  15'sd2,  1'b0},
      '{1'b1, 1'b0, 26'd57, 14'd10, 14'd8, 12'd6, 12'd9, 12'd10,  13'sd6,  15'sd9,  1'b0},
      '{1'b1, 1'b0, 26'd58, 14'd10, 14'd8, 12'd6, 12'd9, 12'd10, -13'sd3,  15'sd0,  1'b1},
      '{1'b1, 1'b0, 26'd75, 14'd10, 14'd8, 12'd6, 12'd9, 12'd10, -13'sd1, -15'sd3,  1'b1},
      '{1'b1, 1'b0, 26'd98, 14'd10, 14'd8, 12'd6, 12'd9, 12'd10,  13'sd1,  15'sd0,  1'b0},
      // R5: beyond total, clamped then wrapped
      '{1'b1, 1'b0, 26'd150,14'd10, 14'd8, 12'd6, 12'd9, 12'd10,  13'sd1,  15'sd1,  1'b0},
      '{1'b1, 1'b0, 26'd89, 14'd10, 14'd8, 12'd6, 12'd9, 12'd10,  13'sd0,  15'sd1,  1'b0},
      // R10: line zero but still in blank
      '{1'b1, 1'b0, 26'd86, 14'd10, 14'd8, 12'd6, 12'd9, 12'd10,  13'sd0, -15'sd2,  1'b1},
      // R8: line mode
      '{1'b0, 1'b0, 26'd3,  14'd10, 14'd8, 12'd6, 12'd9, 12'd10,  13'sd4,  15'sd0,  1'b0},
      '{1'b0, 1'b0, 26'd7,  14'd10, 14'd8, 12'd6, 12'd9, 12'd10, -13'sd2,  15'sd0,  1'b1},
      // R3: interlaced, blank 7..9 total 11 -> 4, 4, 5
      '{1'b1, 1'b1, 26'd52, 14'd10, 14'd8, 12'd7, 12'd9, 12'd11,  13'sd1,  15'sd1,  1'b0},
      '{1'b1, 1'b1, 26'd37, 14'd10, 14'd8, 12'd7, 12'd9, 12'd11,  13'sd4,  15'sd9,  1'b0},
      '{1'b1, 1'b1, 26'd38, 14'd10, 14'd8, 12'd7, 12'd9, 12'd11,  13'sd0,  15'sd0,  1'b0},
      '{1'b0, 1'b1, 26'd4,  14'd10, 14'd8, 12'd7, 12'd9, 12'd11,  13'sd0,  15'sd0,  1'b0},
      '{1'b0, 1'b1, 26'd2,  14'd10, 14'd8, 12'd7, 12'd9, 12'd11,  13'sd3,  15'sd0,  1'b0},
      // large mode around the rebased blank entry (R6 R7)
      '{1'b1, 1'b0, 26'd1999900, 14'd2000, 14'd1900, 12'd1000, 12'd1100, 12'd1125, -13'sd100, 15'sd0, 1'b1},
      '{1'b1, 1'b0, 26'd1999899, 14'd2000, 14'd1900, 12'd1000, 12'd1100, 12'd1125, 13'sd1024, 15'sd1999, 1'b0}
   };

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 start = 1'b0;
   logic                 pix_mode = 1'b0;
   logic                 interlace = 1'b0;
   logic [PW-1:0]        raw_pos = '0;
   logic [HW-1:0]        htotal = '0;
   logic [HW-1:0]        hsync_start = '0;
   logic [LW-1:0]        vbl_start = '0;
   logic [LW-1:0]        vbl_end = '0;
   logic [LW-1:0]        vtotal = '0;
   logic                 busy, done, in_vbl;
   logic signed [LW:0]   vpos;
   logic signed [HW:0]   hpos;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   scanpos_calc #(.LW(LW), .HW(HW)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .pix_mode    (pix_mode),
      .interlace   (interlace),
      .raw_pos     (raw_pos),
      .htotal      (htotal),
      .hsync_start (hsync_start),
      .vbl_start   (vbl_start),
      .vbl_end     (vbl_end),
      .vtotal      (vtotal),
      .busy        (busy),
      .done        (done),
      .in_vbl      (in_vbl),
      .vpos        (vpos),
      .hpos        (hpos)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      pix_mode    = v.pix;
      interlace   = v.il;
      raw_pos     = v.raw;
      htotal      = v.ht;
      hsync_start = v.hs;
      vbl_start   = v.vs;
      vbl_end     = v.ve;
      vtotal      = v.vt;
   endtask

   task automatic wait_done(output bit seen);
      seen = 1'b0;
      for (int k = 0; k < 200; k++) begin
         if (done) begin
            seen = 1'b1;
            break;
         end
         @(negedge clk);
      end
   endtask

   task automatic check_result(input vec_t v, input string tag);
      chk(vpos == v.ev, {tag, " vpos"}, int'(vpos), int'(v.ev));
      chk(hpos == v.eh, {tag, " hpos"}, int'(hpos), int'(v.eh));
      chk(in_vbl == v.eb, {tag, " in_vbl R10"}, int'(in_vbl), int'(v.eb));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      bit seen;
      int extra;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      chk(busy == 1'b0, "R11 busy", int'(busy), 0);
      chk(done == 1'b0, "R11 done", int'(done), 0);
      chk(in_vbl == 1'b0, "R11 in_vbl", int'(in_vbl), 0);
      chk(vpos == 0, "R11 vpos", int'(vpos), 0);
      chk(hpos == 0, "R11 hpos", int'(hpos), 0);

      for (int i = 0; i < NV; i++) begin
         string tag;
         if (VEC[i].pix)
            tag = $sformatf("vec%0d R3 R4 R5 R6 R7 R9", i);
         else
            tag = $sformatf("vec%0d R3 R7 R8", i);
         drive(VEC[i]);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         chk(busy == 1'b1, "R1 busy after start", int'(busy), 1);
         wait_done(seen);
         chk(seen, "R1 done seen", int'(seen), 1);
         check_result(VEC[i], tag);
         @(negedge clk);
         chk(done == 1'b0, "R1 done one cycle", int'(done), 0);
         chk(vpos == VEC[i].ev, "R1 vpos held", int'(vpos), int'(VEC[i].ev));
         @(negedge clk);
      end

      // R2: second start while busy is ignored
      drive(VEC[16]);
      start = 1'b1;
      @(negedge clk);
      drive(VEC[9]);
      chk(busy == 1'b1, "R2 busy", int'(busy), 1);
      @(negedge clk);
      start = 1'b0;
      wait_done(seen);
      chk(seen, "R2 done seen", int'(seen), 1);
      check_result(VEC[16], "R2 result of first request");
      extra = 0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (done) extra++;
      end
      chk(extra == 0, "R2 no extra done", extra, 0);
      chk(busy == 1'b0, "R2 idle", int'(busy), 0);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule